// File: doc/BRIEF.md
# Floppy Disk Controller Host Register Interface

This block is the byte-wide I/O register front end that a host processor uses to drive a floppy disk controller. It watches an 8-bit I/O address bus and claims an aligned window of eight ports at a base address. Within that window it serves three readable registers: controller status, result type and result byte. It accepts the two bytes of a 16-bit pointer to a command parameter block and a soft-reset command. Writing the upper pointer byte launches a command: the block raises a one-cycle start pulse and presents the full pointer to the command engine that sits behind it.

The engine reports each completion with a one-cycle done strobe, a 2-bit result type, an error byte and the 2-bit interrupt control field of the command's channel word. The block keeps the interrupt flag and the latched per-drive ready bits. It drives a registered interrupt request and selects what the host sees when it reads the result byte. Reading the result type is the host's acknowledge: that read clears the interrupt flag.

Top module: `fdc_host_regs`

## Requirements
- R1: A read of offset 0 returns status: bit 0 drive 0 ready, bit 1 drive 1 ready, bit 2 interrupt flag, bit 3 controller present (always 1), bit 4 double-density present (always 1), bit 5 drive 2 ready, bit 6 drive 3 ready, bit 7 zero.
- R2: Read data is registered. For a read strobed at a clock edge, `io_rdata` holds the value from the following edge until the next edge. In any cycle after an edge with no decoded read, it is 0x00.
- R3: A write to offset 1 loads pointer bits 7:0. A write to offset 2 loads pointer bits 15:8, and `cmd_start` is high for exactly the cycle after that edge, with `cmd_ptr` already carrying the new value.
- R4: A read of offset 1 returns the current result type in bits 1:0 and zero in bits 7:2. Type 00 means completed with error status, and type 10 means a ready-change report.
- R5: Reading offset 1 clears the interrupt flag, and with it status bit 2 and `irq`, from the next cycle. A completion in the same cycle takes priority and leaves the flag set.
- R6: An `eng_done` strobe sets the interrupt flag and latches `eng_type`. When the type is 00 it also stores `eng_byte` as the error byte.
- R7: A read of offset 3 returns {drive1, drive0, drive3, drive2, 4'b0000} when the type is 10 and a ready change is pending. Otherwise it returns the error byte. A completion of type 10 marks a ready change pending, and any other completion clears it.
- R8: A write to offset 7, like `rst`, clears the interrupt flag, error byte, result type and pending ready change. It also reloads the four ready bits from `media_present`, which are not sampled at any other time. The soft reset takes priority over a completion in the same cycle.
- R9: `irq` is high exactly while the interrupt flag is set, unless the last completion's `eng_ictl` was 01.
- R10: Reads of offsets 2, 4, 5, 6 and 7 and accesses outside the eight-port window return 0x00. Writes to offsets 0, 3, 4, 5 and 6 and writes outside the window change no register and raise no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O port address |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered host read data |
| media_present | input | 4 | Per-drive media indication, sampled at reset |
| eng_done | input | 1 | Engine completion strobe |
| eng_type | input | 2 | Result type of the completed command |
| eng_byte | input | 8 | Error flags of the completed command |
| eng_ictl | input | 2 | Interrupt control field of the command channel word |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_ptr | output | PTR_W | Parameter block pointer |
| irq | output | 1 | Registered interrupt request |

## Verification
Several media patterns are applied through reset, including one with drive 2 empty and one with only drive 2 present. This shows whether each status bit and each bit of the ready-change byte comes from the right drive. Completions of each result type, with interrupt control 00 and 01, show apart the error-byte path, the ready-change path and the interrupt mask. Collisions test the stated priorities: a completion in the same cycle as a result-type read, and a soft reset in the same cycle as a completion. Writes to read-only offsets, reads of undefined offsets and accesses just outside the window show whether decoding claims too much or too little.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 3;
  localparam int N_DRV  = 4;

  localparam logic [OFS_W-1:0] OFS_STAT  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_LOTYP = 3'd1;
  localparam logic [OFS_W-1:0] OFS_HI    = 3'd2;
  localparam logic [OFS_W-1:0] OFS_RBYTE = 3'd3;
  localparam logic [OFS_W-1:0] OFS_SRST  = 3'd7;

  localparam logic [1:0] RT_ERR    = 2'b00;
  localparam logic [1:0] RT_RDYCHG = 2'b10;
  localparam logic [1:0] ICTL_OFF  = 2'b01;

  typedef struct packed {
    logic rd_stat;
    logic rd_type;
    logic rd_rbyte;
    logic wr_lo;
    logic wr_hi;
    logic wr_srst;
  } strobe_t;

  // drive-ready bits sit apart; both presence bits read as one
  function automatic logic [DATA_W-1:0] pack_status(input logic [N_DRV-1:0] rdy,
                                                    input logic flag);
    return {1'b0, rdy[3], rdy[2], 1'b1, 1'b1, flag, rdy[1], rdy[0]};
  endfunction

  function automatic logic [DATA_W-1:0] pack_rdychg(input logic [N_DRV-1:0] rdy);
    return {rdy[1], rdy[0], rdy[3], rdy[2], 4'b0000};
  endfunction
endpackage

// File: rtl/fdc_addr_dec.sv
module fdc_addr_dec
  import fdc_regs_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h78
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output strobe_t           stb
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic             hit;
  logic [OFS_W-1:0] ofs;

  assign hit = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign ofs = addr[OFS_W-1:0];

  always_comb begin
    stb          = '0;
    stb.rd_stat  = rd && hit && (ofs == OFS_STAT);
    stb.rd_type  = rd && hit && (ofs == OFS_LOTYP);
    stb.rd_rbyte = rd && hit && (ofs == OFS_RBYTE);
    stb.wr_lo    = wr && hit && (ofs == OFS_LOTYP);
    stb.wr_hi    = wr && hit && (ofs == OFS_HI);
    stb.wr_srst  = wr && hit && (ofs == OFS_SRST);
  end

  if (TAG_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed the offset width");
  end
endmodule

// File: rtl/fdc_ptr_launch.sv
module fdc_ptr_launch
  import fdc_regs_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  cmd_ptr,
  output logic              cmd_start
);
  localparam int HI_W = PTR_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      hi_q      <= '0;
      cmd_start <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata[HI_W-1:0];
      cmd_start <= wr_hi;
    end
  end

  assign cmd_ptr = {hi_q, lo_q};
endmodule

// File: rtl/fdc_result_regs.sv
module fdc_result_regs
  import fdc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              rd_type,
  input  logic [N_DRV-1:0]  media_present,
  input  logic              eng_done,
  input  logic [1:0]        eng_type,
  input  logic [DATA_W-1:0] eng_byte,
  input  logic [1:0]        eng_ictl,
  output logic              intff,
  output logic [1:0]        rtype,
  output logic [DATA_W-1:0] err_byte,
  output logic              chg_pend,
  output logic [N_DRV-1:0]  rdy,
  output logic              irq
);
  logic              intff_n, chg_n;
  logic [1:0]        type_n, ictl_n, ictl_q;
  logic [DATA_W-1:0] err_n;

  always_comb begin
    intff_n = intff;
    chg_n   = chg_pend;
    type_n  = rtype;
    ictl_n  = ictl_q;
    err_n   = err_byte;
    if (eng_done) begin
      intff_n = 1'b1;
      type_n  = eng_type;
      ictl_n  = eng_ictl;
      chg_n   = (eng_type == RT_RDYCHG);
      if (eng_type == RT_ERR) err_n = eng_byte;
    end else if (rd_type) begin
      intff_n = 1'b0;
    end
    if (soft_rst) begin
      intff_n = 1'b0;
      chg_n   = 1'b0;
      type_n  = RT_ERR;
      ictl_n  = 2'b00;
      err_n   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intff    <= 1'b0;
      chg_pend <= 1'b0;
      rtype    <= RT_ERR;
      ictl_q   <= 2'b00;
      err_byte <= '0;
      irq      <= 1'b0;
    end else begin
      intff    <= intff_n;
      chg_pend <= chg_n;
      rtype    <= type_n;
      ictl_q   <= ictl_n;
      err_byte <= err_n;
      irq      <= intff_n && (ictl_n != ICTL_OFF);
    end
  end

  for (genvar d = 0; d < N_DRV; d++) begin : g_rdy
    always_ff @(posedge clk) begin
      if (rst || soft_rst) rdy[d] <= media_present[d];
    end
  end
endmodule

// File: rtl/fdc_rd_mux.sv
module fdc_rd_mux
  import fdc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic              intff,
  input  logic [1:0]        rtype,
  input  logic [DATA_W-1:0] err_byte,
  input  logic              chg_pend,
  input  logic [N_DRV-1:0]  rdy,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (stb.rd_stat)
      sel = pack_status(rdy, intff);
    else if (stb.rd_type)
      sel = {{(DATA_W-2){1'b0}}, rtype};
    else if (stb.rd_rbyte)
      sel = (rtype == RT_RDYCHG && chg_pend) ? pack_rdychg(rdy) : err_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_regs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h78,
  parameter int                PTR_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [3:0]        media_present,
  input  logic              eng_done,
  input  logic [1:0]        eng_type,
  input  logic [7:0]        eng_byte,
  input  logic [1:0]        eng_ictl,
  output logic              cmd_start,
  output logic [PTR_W-1:0]  cmd_ptr,
  output logic              irq
);
  strobe_t           stb;
  logic              intff;
  logic [1:0]        rtype;
  logic [DATA_W-1:0] err_byte;
  logic              chg_pend;
  logic [N_DRV-1:0]  rdy;

  fdc_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(io_addr), .rd(io_rd), .wr(io_wr), .stb(stb)
  );

  fdc_ptr_launch #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .wr_lo(stb.wr_lo), .wr_hi(stb.wr_hi),
    .wdata(io_wdata), .cmd_ptr(cmd_ptr), .cmd_start(cmd_start)
  );

  fdc_result_regs u_res (
    .clk(clk), .rst(rst), .soft_rst(stb.wr_srst), .rd_type(stb.rd_type),
    .media_present(media_present), .eng_done(eng_done), .eng_type(eng_type),
    .eng_byte(eng_byte), .eng_ictl(eng_ictl), .intff(intff), .rtype(rtype),
    .err_byte(err_byte), .chg_pend(chg_pend), .rdy(rdy), .irq(irq)
  );

  fdc_rd_mux u_mux (
    .clk(clk), .rst(rst), .stb(stb), .intff(intff), .rtype(rtype),
    .err_byte(err_byte), .chg_pend(chg_pend), .rdy(rdy), .rdata(io_rdata)
  );
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h78
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic              eng_done,
  input logic              cmd_start,
  input logic              irq,
  input logic              intff
);
  logic       in_win;
  logic [2:0] ofs;
  assign in_win = (io_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
  assign ofs    = io_addr[2:0];

  p_status_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    (io_rd && in_win && ofs == 3'd0) |=> (io_rdata[7] == 1'b0 && io_rdata[4:3] == 2'b11));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> (io_rdata == 8'h00));

  p_launch_r3: assert property (@(posedge clk) disable iff (rst)
    (io_wr && in_win && ofs == 3'd2) |=> cmd_start);

  p_launch_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_start) |-> $past(io_wr && in_win && ofs == 3'd2));

  p_type_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && in_win && ofs == 3'd1) |=> (io_rdata[7:2] == 6'd0));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (io_rd && in_win && ofs == 3'd1 && !eng_done) |=> !intff);

  p_done_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !(io_wr && in_win && ofs == 3'd7)) |=> intff);

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (io_wr && in_win && ofs == 3'd7) |=> (!intff && !irq));

  p_irq_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> intff);
endmodule

bind fdc_host_regs fdc_host_regs_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_rdata(io_rdata), .eng_done(eng_done), .cmd_start(cmd_start),
  .irq(irq), .intff(intff)
);

// File: tb/sim_fdc_host_regs.sv
`timescale 1ns/1ps
module sim_fdc_host_regs;
  localparam logic [7:0] BASE = 8'h78;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] io_addr = 8'h00;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic [3:0] media_present = 4'b1011;
  logic       eng_done = 1'b0;
  logic [1:0] eng_type = 2'b00, eng_ictl = 2'b00;
  logic [7:0] eng_byte = 8'h00;
  logic       cmd_start, irq;
  logic [15:0] cmd_ptr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fdc_host_regs u0 (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .media_present(media_present),
    .eng_done(eng_done), .eng_type(eng_type), .eng_byte(eng_byte),
    .eng_ictl(eng_ictl), .cmd_start(cmd_start), .cmd_ptr(cmd_ptr), .irq(irq)
  );

  // behavioural reference model, advanced at each rising edge
  int m_flag, m_type, m_err, m_chg, m_ictl, m_lo, m_hi, m_start, m_rdata, m_irq;
  int m_rdy[4];
  string m_tag = "R2";

  always @(posedge clk) begin
    int off, nxt;
    bit inw;
    inw = (io_addr >> 3) == (BASE >> 3);
    off = io_addr % 8;
    if (rst) begin
      m_flag = 0; m_type = 0; m_err = 0; m_chg = 0; m_ictl = 0;
      m_lo = 0; m_hi = 0; m_start = 0; m_rdata = 0; m_irq = 0;
      for (int d = 0; d < 4; d++) m_rdy[d] = media_present[d];
      m_tag = "R8";
    end else begin
      nxt = 0; m_tag = "R2";
      if (io_rd && inw) begin
        if (off == 0) begin
          nxt = m_rdy[0] + 2*m_rdy[1] + 4*m_flag + 8 + 16 + 32*m_rdy[2] + 64*m_rdy[3];
          m_tag = "R1";
        end else if (off == 1) begin
          nxt = m_type; m_tag = "R4";
        end else if (off == 3) begin
          if (m_type == 2 && m_chg == 1)
            nxt = 16*m_rdy[2] + 32*m_rdy[3] + 64*m_rdy[0] + 128*m_rdy[1];
          else nxt = m_err;
          m_tag = "R7";
        end else m_tag = "R10";
      end
      m_rdata = nxt;
      m_start = (io_wr && inw && off == 2) ? 1 : 0;
      if (io_wr && inw && off == 1) m_lo = io_wdata;
      if (io_wr && inw && off == 2) m_hi = io_wdata;
      if (io_wr && inw && off == 7) begin
        m_flag = 0; m_type = 0; m_err = 0; m_chg = 0; m_ictl = 0;
        for (int d = 0; d < 4; d++) m_rdy[d] = media_present[d];
      end else if (eng_done) begin
        m_flag = 1; m_type = eng_type; m_ictl = eng_ictl;
        m_chg = (eng_type == 2) ? 1 : 0;
        if (eng_type == 0) m_err = eng_byte;
      end else if (io_rd && inw && off == 1) m_flag = 0;
      m_irq = (m_flag == 1 && m_ictl != 1) ? 1 : 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(m_tag, io_rdata, m_rdata);
      check("R3", cmd_start, m_start);
      check("R3", cmd_ptr, m_hi * 256 + m_lo);
      check("R9", irq, m_irq);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    step(); io_addr = a; io_rd = 1'b1;
    step(); io_rd = 1'b0;
    @(negedge clk); #1;
    check(tag, io_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(); io_addr = a; io_wdata = d; io_wr = 1'b1;
    step(); io_wr = 1'b0;
  endtask

  task automatic done(input logic [1:0] t, input logic [7:0] b, input logic [1:0] ic);
    step(); eng_type = t; eng_byte = b; eng_ictl = ic; eng_done = 1'b1;
    step(); eng_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #1;
    check("R8 reset rdata", io_rdata, 0);
    check("R8 reset irq", irq, 0);
    rd(BASE + 0, 8'h5B, "R1 status after reset");
    rd(BASE + 1, 8'h00, "R4 type after reset");
    // error completion with interrupts enabled
    done(2'b00, 8'h28, 2'b00);
    @(negedge clk); #1; check("R9 irq raised", irq, 1);
    rd(BASE + 0, 8'h5F, "R6 flag in status");
    rd(BASE + 3, 8'h28, "R6 error byte");
    rd(BASE + 1, 8'h00, "R4 type 00");
    rd(BASE + 0, 8'h5B, "R5 flag cleared");
    check("R5 irq cleared", irq, 0);
    // completion with interrupts disabled
    done(2'b00, 8'h80, 2'b01);
    @(negedge clk); #1; check("R9 irq masked", irq, 0);
    rd(BASE + 0, 8'h5F, "R9 flag still set");
    rd(BASE + 1, 8'h00, "R5 ack");
    // ready-change completion
    done(2'b10, 8'h00, 2'b00);
    rd(BASE + 3, 8'hE0, "R7 ready change byte");
    rd(BASE + 1, 8'h02, "R4 type 10");
    done(2'b11, 8'h11, 2'b00);
    rd(BASE + 3, 8'h80, "R7 other type gives error byte");
    // read of type in same cycle as completion
    step(); io_addr = BASE + 1; io_rd = 1'b1;
    eng_type = 2'b00; eng_byte = 8'h04; eng_ictl = 2'b00; eng_done = 1'b1;
    step(); io_rd = 1'b0; eng_done = 1'b0;
    rd(BASE + 0, 8'h5F, "R5 completion wins over ack");
    // pointer load and launch
    wr(BASE + 1, 8'h34);
    wr(BASE + 2, 8'h12);
    check("R3 pointer", cmd_ptr, 16'h1234);
    // ignored writes and undefined reads
    wr(BASE + 0, 8'hFF);
    wr(BASE + 3, 8'hFF);
    wr(BASE + 5, 8'hFF);
    wr(BASE - 8 + 2, 8'h99);
    wr(BASE + 8 + 7, 8'h00);
    check("R10 pointer unchanged", cmd_ptr, 16'h1234);
    rd(BASE + 0, 8'h5F, "R10 status unchanged");
    rd(BASE + 3, 8'h04, "R10 error byte unchanged");
    rd(BASE + 2, 8'h00, "R10 read offset 2");
    rd(BASE + 5, 8'h00, "R10 read offset 5");
    rd(BASE + 7, 8'h00, "R10 read offset 7");
    rd(BASE + 8, 8'h00, "R10 read outside window");
    // media change alone is not sampled
    media_present = 4'b0100;
    rd(BASE + 0, 8'h5F, "R8 media not sampled");
    // soft reset colliding with a completion
    step(); io_addr = BASE + 7; io_wr = 1'b1;
    eng_type = 2'b00; eng_byte = 8'h40; eng_ictl = 2'b00; eng_done = 1'b1;
    step(); io_wr = 1'b0; eng_done = 1'b0;
    rd(BASE + 0, 8'h38, "R8 status after soft reset");
    rd(BASE + 3, 8'h00, "R8 error byte cleared");
    rd(BASE + 1, 8'h00, "R8 type cleared");
    done(2'b10, 8'h00, 2'b00);
    rd(BASE + 3, 8'h10, "R7 drive 2 alone");
    check("R9 irq after ready change", irq, 1);
    repeat (3) step();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule